// File: doc/BRIEF.md
# Bus Data Error Status Logger

This block keeps the error status that a system-bus interface reports for data transfers. Each of its syndrome lanes can report a correctable read ECC error, a correctable write ECC error or an uncorrectable error in any cycle. The block turns these reports into sticky flags that software clears by writing ones. It also sets a flag when a second correctable write error arrives while the first one is still logged.

Alongside the flags, the block keeps a lane mask. The mask names the syndrome lanes that hold status for the most significant error currently logged. Only an error that ranks strictly higher than the logged one replaces the mask.

Each accepted error produces a one-cycle pulse on the bus data-error line, unless that error type is disabled by its control bit. When interrupts are enabled, an error interrupt request follows the pulse one cycle later. The request stays high while any flag that is not disabled remains set.

Top module: `bus_data_err_logger`

## Requirements
- R1: While reset is asserted, and right after it is released, all flags, the lane mask, the bus data-error output and the interrupt request are 0.
- R2: A correctable read report on any lane sets flag bit 1 at the next clock edge.
- R3: A correctable write report on any lane sets flag bit 0 at the next clock edge.
- R4: An uncorrectable report on any lane sets flag bit 2 at the next clock edge.
- R5: Flag bit 3 sets when a correctable write report arrives while flag bit 0 is already set. It does not set on the first correctable write report.
- R6: A register write clears each flag whose bit is 1 in the write data (bit 0 write, bit 1 read, bit 2 uncorrectable, bit 3 second write). A 0 bit leaves its flag unchanged, and with no write strobe the data is ignored.
- R7: If a write clears a flag in the same cycle that a report sets it, the flag ends up set.
- R8: Significance ranks uncorrectable over read over write. A lane that reports several types counts at its highest rank. Bit i of the lane mask stands for lane i. When the highest incoming rank exceeds the rank of the highest flag held before that edge, the mask becomes the set of lanes reporting at that rank. Otherwise the mask is unchanged.
- R9: The bus data-error output is high in the cycle after a cycle with an uncorrectable report, an enabled read report or an enabled write report. A set disable bit suppresses the pulse for its type.
- R10: With interrupts enabled, the interrupt request rises in the cycle after a bus data-error pulse. It stays high while an uncorrectable, enabled read or enabled write flag remains set. With interrupts disabled, the request is 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| unc_err_i | input | NUM_LANES | Per-lane uncorrectable error pulse |
| crd_err_i | input | NUM_LANES | Per-lane correctable read error pulse |
| cwr_err_i | input | NUM_LANES | Per-lane correctable write error pulse |
| reg_wr_i | input | 1 | Status register write strobe |
| reg_wdata_i | input | 4 | Write-one-to-clear data for the flags |
| crd_dis_i | input | 1 | Suppress bus error signalling for read errors |
| cwr_dis_i | input | 1 | Suppress bus error signalling for write errors |
| irq_en_i | input | 1 | Interrupt enable |
| err_flags_o | output | 4 | Flags: bit 0 write, 1 read, 2 uncorrectable, 3 second write |
| lane_mask_o | output | NUM_LANES | Lanes holding status for the logged error |
| bus_data_err_o | output | 1 | One-cycle bus data-error pulse |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
The bench builds the block with the default of four lanes. With four lanes, reports on several lanes at once, mixed ranks across lanes and a single lane carrying several types all occur. This lets the mask capture be checked against multi-bit patterns. Random disable and interrupt-enable changes, together with clears that land in the same cycle as new reports, exercise the set-wins rule and the hold-off of the interrupt request.

// File: rtl/bdel_pkg.sv
package bdel_pkg;

    localparam int FLAG_W = 4;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_CWR  = 2'd1,
        LVL_CRD  = 2'd2,
        LVL_UNC  = 2'd3
    } lvl_e;

    // packed MSB first: bit3 second write, bit2 uncorrectable, bit1 read, bit0 write
    typedef struct packed {
        logic cwr2;
        logic unc;
        logic crd;
        logic cwr;
    } flags_t;

endpackage

// File: rtl/bdel_lane_arbiter.sv
module bdel_lane_arbiter
    import bdel_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic [NUM_LANES-1:0] unc_i,
    input  logic [NUM_LANES-1:0] crd_i,
    input  logic [NUM_LANES-1:0] cwr_i,
    output lvl_e                 lvl_o,
    output logic [NUM_LANES-1:0] mask_o
);

    lvl_e lane_lvl [NUM_LANES];
    lvl_e top_lvl;

    always_comb begin
        top_lvl = LVL_NONE;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (unc_i[i]) begin
                lane_lvl[i] = LVL_UNC;
            end else if (crd_i[i]) begin
                lane_lvl[i] = LVL_CRD;
            end else if (cwr_i[i]) begin
                lane_lvl[i] = LVL_CWR;
            end else begin
                lane_lvl[i] = LVL_NONE;
            end
            if (lane_lvl[i] > top_lvl) begin
                top_lvl = lane_lvl[i];
            end
        end
    end

    assign lvl_o = top_lvl;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_mask
        assign mask_o[g] = (top_lvl != LVL_NONE) && (lane_lvl[g] == top_lvl);
    end

endmodule

// File: rtl/bdel_flag_file.sv
module bdel_flag_file
    import bdel_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 unc_hit_i,
    input  logic                 crd_hit_i,
    input  logic                 cwr_hit_i,
    input  lvl_e                 in_lvl_i,
    input  logic [NUM_LANES-1:0] in_mask_i,
    input  logic                 clr_en_i,
    input  logic [FLAG_W-1:0]    clr_bits_i,
    output flags_t               flags_o,
    output flags_t               flags_next_o,
    output logic [NUM_LANES-1:0] mask_o
);

    typedef struct packed {
        flags_t               flags;
        logic [NUM_LANES-1:0] mask;
    } state_t;

    state_t s_d, s_q;
    lvl_e   held_lvl;
    flags_t clr;

    always_comb begin
        clr = clr_en_i ? flags_t'(clr_bits_i) : flags_t'('0);

        if (s_q.flags.unc) begin
            held_lvl = LVL_UNC;
        end else if (s_q.flags.crd) begin
            held_lvl = LVL_CRD;
        end else if (s_q.flags.cwr) begin
            held_lvl = LVL_CWR;
        end else begin
            held_lvl = LVL_NONE;
        end

        s_d = s_q;
        // a report in the same cycle outranks the clear
        s_d.flags.cwr  = (s_q.flags.cwr  & ~clr.cwr)  | cwr_hit_i;
        s_d.flags.crd  = (s_q.flags.crd  & ~clr.crd)  | crd_hit_i;
        s_d.flags.unc  = (s_q.flags.unc  & ~clr.unc)  | unc_hit_i;
        s_d.flags.cwr2 = (s_q.flags.cwr2 & ~clr.cwr2) | (cwr_hit_i & s_q.flags.cwr);

        if (in_lvl_i > held_lvl) begin
            s_d.mask = in_mask_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flags_o      = s_q.flags;
    assign flags_next_o = s_d.flags;
    assign mask_o       = s_q.mask;

endmodule

// File: rtl/bdel_signal_gen.sv
module bdel_signal_gen
    import bdel_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   unc_hit_i,
    input  logic   crd_hit_i,
    input  logic   cwr_hit_i,
    input  logic   crd_dis_i,
    input  logic   cwr_dis_i,
    input  logic   irq_en_i,
    input  flags_t flags_next_i,
    output logic   bus_err_o,
    output logic   irq_o
);

    typedef struct packed {
        logic bus_err;
        logic irq;
    } sig_t;

    sig_t s_d, s_q;
    logic pending;

    always_comb begin
        pending = flags_next_i.unc
                | (flags_next_i.crd & ~crd_dis_i)
                | (flags_next_i.cwr & ~cwr_dis_i);

        s_d.bus_err = unc_hit_i
                    | (crd_hit_i & ~crd_dis_i)
                    | (cwr_hit_i & ~cwr_dis_i);
        s_d.irq     = irq_en_i & (s_q.bus_err | (s_q.irq & pending));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_err_o = s_q.bus_err;
    assign irq_o     = s_q.irq;

endmodule

// File: rtl/bus_data_err_logger.sv
module bus_data_err_logger
    import bdel_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_LANES-1:0] unc_err_i,
    input  logic [NUM_LANES-1:0] crd_err_i,
    input  logic [NUM_LANES-1:0] cwr_err_i,
    input  logic                 reg_wr_i,
    input  logic [3:0]           reg_wdata_i,
    input  logic                 crd_dis_i,
    input  logic                 cwr_dis_i,
    input  logic                 irq_en_i,
    output logic [3:0]           err_flags_o,
    output logic [NUM_LANES-1:0] lane_mask_o,
    output logic                 bus_data_err_o,
    output logic                 err_irq_o
);

    lvl_e                 in_lvl;
    logic [NUM_LANES-1:0] in_mask;
    logic                 unc_hit, crd_hit, cwr_hit;
    flags_t               flags_q, flags_next;

    assign unc_hit = |unc_err_i;
    assign crd_hit = |crd_err_i;
    assign cwr_hit = |cwr_err_i;

    bdel_lane_arbiter #(.NUM_LANES(NUM_LANES)) u_arb (
        .unc_i  (unc_err_i),
        .crd_i  (crd_err_i),
        .cwr_i  (cwr_err_i),
        .lvl_o  (in_lvl),
        .mask_o (in_mask)
    );

    bdel_flag_file #(.NUM_LANES(NUM_LANES)) u_flags (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .unc_hit_i    (unc_hit),
        .crd_hit_i    (crd_hit),
        .cwr_hit_i    (cwr_hit),
        .in_lvl_i     (in_lvl),
        .in_mask_i    (in_mask),
        .clr_en_i     (reg_wr_i),
        .clr_bits_i   (reg_wdata_i),
        .flags_o      (flags_q),
        .flags_next_o (flags_next),
        .mask_o       (lane_mask_o)
    );

    bdel_signal_gen u_sig (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .unc_hit_i    (unc_hit),
        .crd_hit_i    (crd_hit),
        .cwr_hit_i    (cwr_hit),
        .crd_dis_i    (crd_dis_i),
        .cwr_dis_i    (cwr_dis_i),
        .irq_en_i     (irq_en_i),
        .flags_next_i (flags_next),
        .bus_err_o    (bus_data_err_o),
        .irq_o        (err_irq_o)
    );

    assign err_flags_o = flags_q;

endmodule

// File: rtl/bdel_checker.sv
module bdel_checker #(
    parameter int NUM_LANES = 4
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [NUM_LANES-1:0] unc_err_i,
    input logic [NUM_LANES-1:0] crd_err_i,
    input logic [NUM_LANES-1:0] cwr_err_i,
    input logic                 irq_en_i,
    input logic [3:0]           err_flags_o,
    input logic [NUM_LANES-1:0] lane_mask_o,
    input logic                 bus_data_err_o,
    input logic                 err_irq_o
);

    a_r1_reset_clear: assert property (@(posedge clk_i)
        !rst_ni |=> (err_flags_o == '0 && lane_mask_o == '0 && !bus_data_err_o && !err_irq_o));

    a_r2_read_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|crd_err_i) |=> err_flags_o[1]);

    a_r3_write_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|cwr_err_i) |=> err_flags_o[0]);

    a_r4_unc_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|unc_err_i) |=> err_flags_o[2]);

    a_r5_second_needs_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_flags_o[3]) |-> $past(err_flags_o[0]));

    a_r8_mask_holds_when_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (unc_err_i == '0 && crd_err_i == '0 && cwr_err_i == '0) |=> $stable(lane_mask_o));

    a_r9_unc_pulses: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|unc_err_i) |=> bus_data_err_o);

    a_r10_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_en_i |=> !err_irq_o);

    a_r10_irq_after_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_irq_o) |-> $past(bus_data_err_o));

endmodule

bind bus_data_err_logger bdel_checker #(.NUM_LANES(NUM_LANES)) u_bdel_checker (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .unc_err_i      (unc_err_i),
    .crd_err_i      (crd_err_i),
    .cwr_err_i      (cwr_err_i),
    .irq_en_i       (irq_en_i),
    .err_flags_o    (err_flags_o),
    .lane_mask_o    (lane_mask_o),
    .bus_data_err_o (bus_data_err_o),
    .err_irq_o      (err_irq_o)
);

// File: tb/test_bus_data_err_logger.sv
module test_bus_data_err_logger;

    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] unc = '0, crd = '0, cwr = '0;
    logic          wr = 1'b0;
    logic [3:0]    wdata = '0;
    logic          dis_rd = 1'b0, dis_wr = 1'b0, ien = 1'b0;
    logic [3:0]    flags;
    logic [NL-1:0] mask;
    logic          berr, irq;

    int checks = 0;
    int errors = 0;

    logic [3:0]    m_flags = '0;
    logic [NL-1:0] m_mask = '0;
    logic          m_bus = 1'b0, m_irq = 1'b0;

    always #5 clk = ~clk;

    bus_data_err_logger #(.NUM_LANES(NL)) i_bus_data_err_logger (
        .clk_i(clk), .rst_ni(rst_n),
        .unc_err_i(unc), .crd_err_i(crd), .cwr_err_i(cwr),
        .reg_wr_i(wr), .reg_wdata_i(wdata),
        .crd_dis_i(dis_rd), .cwr_dis_i(dis_wr), .irq_en_i(ien),
        .err_flags_o(flags), .lane_mask_o(mask),
        .bus_data_err_o(berr), .err_irq_o(irq)
    );

    function automatic logic [1:0] rank(input logic u, input logic c, input logic w);
        return u ? 2'd3 : (c ? 2'd2 : (w ? 2'd1 : 2'd0));
    endfunction

    // reference model, advanced on every rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flags = '0; m_mask = '0; m_bus = 1'b0; m_irq = 1'b0;
        end else begin
            logic [1:0]    top, held;
            logic [NL-1:0] nmask;
            logic [3:0]    clr, nf;
            logic          pend;
            top = 2'd0;
            for (int i = 0; i < NL; i++)
                if (rank(unc[i], crd[i], cwr[i]) > top) top = rank(unc[i], crd[i], cwr[i]);
            nmask = '0;
            for (int i = 0; i < NL; i++)
                nmask[i] = (top != 2'd0) && (rank(unc[i], crd[i], cwr[i]) == top);
            held = rank(m_flags[2], m_flags[1], m_flags[0]);
            clr = wr ? wdata : 4'd0;
            nf[0] = (m_flags[0] & ~clr[0]) | (|cwr);
            nf[1] = (m_flags[1] & ~clr[1]) | (|crd);
            nf[2] = (m_flags[2] & ~clr[2]) | (|unc);
            nf[3] = (m_flags[3] & ~clr[3]) | ((|cwr) & m_flags[0]);
            pend = nf[2] | (nf[1] & ~dis_rd) | (nf[0] & ~dis_wr);
            m_irq = ien & (m_bus | (m_irq & pend));
            m_bus = (|unc) | ((|crd) & ~dis_rd) | ((|cwr) & ~dis_wr);
            if (top > held) m_mask = nmask;
            m_flags = nf;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_model();
        chk("R3 write flag", 32'(flags[0]), 32'(m_flags[0]));
        chk("R2 read flag", 32'(flags[1]), 32'(m_flags[1]));
        chk("R4 uncorrectable flag", 32'(flags[2]), 32'(m_flags[2]));
        chk("R5 second write flag", 32'(flags[3]), 32'(m_flags[3]));
        chk("R8 lane mask", 32'(mask), 32'(m_mask));
        chk("R9 bus error pulse", 32'(berr), 32'(m_bus));
        chk("R10 interrupt", 32'(irq), 32'(m_irq));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        check_model();
        unc = '0; crd = '0; cwr = '0; wr = 1'b0; wdata = '0;
    endtask

    task automatic clear_all();
        wr = 1'b1; wdata = 4'hF;
        step();
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R1 flags in reset", 32'(flags), 0);
        chk("R1 mask in reset", 32'(mask), 0);
        rst_n = 1'b1;
        step();
        chk("R1 outputs after reset", {26'd0, flags, berr, irq}, 0);
        ien = 1'b1;

        // R5: first write error alone, then a second one
        cwr = 4'b0001; step();
        chk("R5 no second flag on first", 32'(flags[3]), 0);
        chk("R9 write pulse", 32'(berr), 1);
        step();
        chk("R10 irq after pulse", 32'(irq), 1);
        cwr = 4'b0100; step();
        chk("R5 second flag set", 32'(flags[3]), 1);

        // R6: zero write and unstrobed data do nothing, then clear bit 0
        wr = 1'b1; wdata = 4'h0; step();
        chk("R6 zero write keeps flags", 32'(flags), 32'h9);
        wr = 1'b0; wdata = 4'hF; step();
        chk("R6 no strobe keeps flags", 32'(flags), 32'h9);
        wr = 1'b1; wdata = 4'h1; step();
        chk("R6 bit0 cleared", 32'(flags), 32'h8);
        step();
        chk("R10 irq drops when none pending", 32'(irq), 0);
        clear_all();

        // R8: read on lanes 1,2 then write on lane 3 then unc on lane 0
        crd = 4'b0110; step();
        chk("R8 mask from read lanes", 32'(mask), 32'h6);
        cwr = 4'b1000; step();
        chk("R8 lower rank keeps mask", 32'(mask), 32'h6);
        crd = 4'b1000; step();
        chk("R8 equal rank keeps mask", 32'(mask), 32'h6);
        unc = 4'b0001; cwr = 4'b0010; step();
        chk("R8 higher rank replaces mask", 32'(mask), 32'h1);

        // R7: clear and set of the read flag in one cycle
        crd = 4'b0001; wr = 1'b1; wdata = 4'h2; step();
        chk("R7 set wins over clear", 32'(flags[1]), 1);
        clear_all();

        // R9: disabled read report gives no pulse
        dis_rd = 1'b1; crd = 4'b0010; step();
        chk("R9 disabled read no pulse", 32'(berr), 0);
        chk("R2 flag still set", 32'(flags[1]), 1);
        dis_rd = 1'b0; clear_all();

        // R10: interrupts disabled
        ien = 1'b0; unc = 4'b1111; step(); step();
        chk("R10 no irq when disabled", 32'(irq), 0);
        ien = 1'b1; clear_all();

        // random phase
        for (int n = 0; n < 4000; n++) begin
            for (int l = 0; l < NL; l++) begin
                unc[l] = ($urandom % 24) == 0;
                crd[l] = ($urandom % 12) == 0;
                cwr[l] = ($urandom % 10) == 0;
            end
            if (($urandom % 6) == 0) begin
                wr = 1'b1; wdata = 4'($urandom);
            end
            if (($urandom % 64) == 0) dis_rd = ~dis_rd;
            if (($urandom % 64) == 0) dis_wr = ~dis_wr;
            if (($urandom % 100) == 0) ien = ~ien;
            step();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule